// File: doc/BRIEF.md
# Clock-Enable Divider Bank with Committed Ratio Change

This block holds the programmable ratios for four clock dividers that sit after a PLL. Each divider produces a stream of single-cycle clock-enable pulses derived from the input clock. Downstream logic uses these pulses to run at a fraction of the input rate without a separate clock net.

Software programs the ratios through a simple register bus. A write to a divider register changes only a pending copy and does not affect the running dividers. A separate command write snapshots all pending values at once. After that, each divider adopts its new ratio at the next wrap of its own counter, so no pulse is ever shortened or stretched mid-period. A readable status bit stays set until every divider has switched.

Software sequence: write the ratios, issue the command, then poll the status bit until it reads zero.

Top module: `pdiv_bank`

## Requirements
- R1: The four divider registers sit at byte addresses 0x118 (channel 0), 0x11C (channel 1), 0x160 (channel 2) and 0x164 (channel 3). In each one, bit 15 is the enable and bits [4:0] hold the ratio minus one. Reading one returns its pending value with every other bit zero.
- R2: A write to a divider register changes only the pending copy. The enable outputs keep their current ratio until a commit.
- R3: A write with bit 0 set to the command address 0x138 while idle is a commit. Bit 0 of the status register at 0x13C reads 1 from the next cycle.
- R4: After a commit, each channel loads the snapshot on the clock edge that ends its current terminal-count cycle. The channel then counts the new ratio from zero.
- R5: The status bit returns to 0 in the cycle after the last channel has switched.
- R6: A command write made while the status bit reads 1 is ignored.
- R7: Divider writes made during a transition do not alter the ratios being committed. They wait for the next commit.
- R8: A channel whose enable bit is 0 emits no pulses. Its counter still runs, so a later switch still waits for its wrap.
- R9: An enabled channel with ratio N pulses in exactly one cycle out of every N, for N from 1 to 32.
- R10: After reset, every channel is enabled with ratio 1 (a pulse every cycle), every divider register reads 0x8000, and the status bit reads 0.
- R11: The first commit after reset is accepted at once.
- R12: Writes to unmapped addresses have no effect, and reads of them return 0. A command write with bit 0 clear does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that the dividers count |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| clk_en_out | output | 4 | One clock-enable pulse stream per channel |

## Verification
The hardest condition to reach is a second command, together with fresh divider writes, arriving while a transition is still outstanding. This window only exists while at least one channel has a long ratio and has not yet wrapped.

The stimulus first commits a ratio of 8 on one channel, which keeps later transitions open for several cycles. Inside that window it rewrites a pending ratio and issues a second command. Pulse counting afterwards then shows that the first snapshot was the one applied.

A long stretch of random register traffic follows. It is compared every cycle against a behavioural model. This lands commits at every counter phase, including switches of disabled channels.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
    localparam int NUM_DIV  = 4;
    localparam int RATIO_W  = 5;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int EN_BIT   = 15;

    localparam logic [ADDR_W-1:0] CMD_ADDR  = 12'h138;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 12'h13C;

    typedef struct packed {
        logic               en;
        logic [RATIO_W-1:0] div;   // ratio minus one
    } ratio_t;

    localparam ratio_t RATIO_RST = '{en: 1'b1, div: '0};

    function automatic logic [ADDR_W-1:0] div_addr(int idx);
        case (idx)
            0:       return 12'h118;
            1:       return 12'h11C;
            2:       return 12'h160;
            default: return 12'h164;
        endcase
    endfunction

    function automatic ratio_t word_to_ratio(logic [DATA_W-1:0] w);
        ratio_t r;
        r.en  = w[EN_BIT];
        r.div = w[RATIO_W-1:0];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] ratio_to_word(ratio_t r);
        logic [DATA_W-1:0] w;
        w              = '0;
        w[EN_BIT]      = r.en;
        w[RATIO_W-1:0] = r.div;
        return w;
    endfunction
endpackage

// File: rtl/pdiv_regs.sv
module pdiv_regs
    import pdiv_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       busy,
    output ratio_t [NUM_DIV-1:0]       staged,
    output logic                       commit,
    output logic [DATA_W-1:0]          bus_rdata
);
    ratio_t [NUM_DIV-1:0] pending;
    logic   [NUM_DIV-1:0] hit;
    logic                 cmd_wr;

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_dec
        assign hit[g] = (bus_addr == div_addr(g));
    end

    assign cmd_wr = bus_wr && (bus_addr == CMD_ADDR) && bus_wdata[0];
    assign commit = cmd_wr && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= {NUM_DIV{RATIO_RST}};
            staged  <= {NUM_DIV{RATIO_RST}};
        end else begin
            for (int i = 0; i < NUM_DIV; i++) begin
                if (bus_wr && hit[i]) pending[i] <= word_to_ratio(bus_wdata);
            end
            if (commit) staged <= pending;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (hit[i]) bus_rdata = ratio_to_word(pending[i]);
        end
        if (bus_addr == STAT_ADDR) bus_rdata[0] = busy;
    end

    // A command arriving mid-transition must leave the snapshot alone
    assert_busy_go_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && busy) |=> $stable(staged));

    // Ordinary divider writes never reach the snapshot
    assert_pending_only_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != CMD_ADDR) |=> $stable(staged));
endmodule

// File: rtl/pdiv_chan.sv
module pdiv_chan
    import pdiv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   commit,
    input  ratio_t staged,
    output logic   pulse,
    output logic   switching
);
    ratio_t             active;
    logic [RATIO_W-1:0] cnt;
    logic               wrap;

    assign wrap      = (cnt == active.div);
    assign pulse     = active.en && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= RATIO_RST;
            cnt       <= '0;
            switching <= 1'b0;
        end else begin
            if (wrap) begin
                cnt <= '0;
                if (switching) begin
                    active    <= staged;
                    switching <= 1'b0;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (commit) switching <= 1'b1;
        end
    end

    // A switch completes only at the end of a terminal-count cycle
    assert_switch_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(switching) |-> $past(cnt == active.div));

    // Without a pending switch the active ratio is frozen
    assert_active_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !switching |=> $stable(active));

    // Counter never leaves the period window
    assert_cnt_range_R9: assert property (@(posedge clk) disable iff (rst)
        cnt <= active.div);

    // Disabled channel stays silent
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !active.en |-> !pulse);
endmodule

// File: rtl/pdiv_bank.sv
module pdiv_bank
    import pdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_DIV-1:0] clk_en_out
);
    ratio_t [NUM_DIV-1:0] staged;
    logic   [NUM_DIV-1:0] switching;
    logic                 commit;
    logic                 busy;

    assign busy = |switching;

    pdiv_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .staged    (staged),
        .commit    (commit),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_chan
        pdiv_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .commit    (commit),
            .staged    (staged[g]),
            .pulse     (clk_en_out[g]),
            .switching (switching[g])
        );
    end

    // An accepted command raises the status on the following cycle
    assert_busy_after_commit_R3: assert property (@(posedge clk) disable iff (rst)
        commit |=> busy);

    // Status can only rise through an accepted command
    assert_busy_rise_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit));
endmodule

// File: tb/tb_pdiv_bank.sv
`timescale 1ns/1ps
module tb_pdiv_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h000;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  clk_en_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [11:0] OFS [4] = '{12'h118, 12'h11C, 12'h160, 12'h164};

    // behavioural model state
    int m_pen[4], m_pdv[4], m_sen[4], m_sdv[4], m_aen[4], m_adv[4], m_cnt[4];
    bit m_req[4];

    always #2 clk = ~clk;

    pdiv_bank dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en_out(clk_en_out)
    );

    function automatic bit m_busy();
        bit b = 0;
        for (int i = 0; i < 4; i++) b |= m_req[i];
        return b;
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++)
            if (a == OFS[i]) r = (32'(m_pen[i]) << 15) | 32'(m_pdv[i]);
        if (a == 12'h13C) r[0] = m_busy();
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_pen[i] = 1; m_pdv[i] = 0; m_sen[i] = 1; m_sdv[i] = 0;
                m_aen[i] = 1; m_adv[i] = 0; m_cnt[i] = 0; m_req[i] = 0;
            end
        end else begin
            bit was_busy;
            was_busy = m_busy();
            for (int i = 0; i < 4; i++) begin
                if (m_cnt[i] == m_adv[i]) begin
                    m_cnt[i] = 0;
                    if (m_req[i]) begin
                        m_aen[i] = m_sen[i]; m_adv[i] = m_sdv[i]; m_req[i] = 0;
                    end
                end else m_cnt[i]++;
            end
            if (bus_wr) begin
                for (int i = 0; i < 4; i++)
                    if (bus_addr == OFS[i]) begin
                        m_pen[i] = int'(bus_wdata[15]); m_pdv[i] = int'(bus_wdata[4:0]);
                    end
                if (bus_addr == 12'h138 && bus_wdata[0] && !was_busy)
                    for (int i = 0; i < 4; i++) begin
                        m_sen[i] = m_pen[i]; m_sdv[i] = m_pdv[i]; m_req[i] = 1;
                    end
            end
        end
    end

    // per-cycle comparison against the model
    always begin
        @(negedge clk);
        #1;
        if (!rst && !done) begin
            for (int i = 0; i < 4; i++) begin
                bit e;
                e = (m_aen[i] != 0) && (m_cnt[i] == m_adv[i]);
                n_cmp++;
                if (clk_en_out[i] !== e) begin
                    n_bad++;
                    $display("FAIL R4/R9 ch%0d pulse actual=%b expected=%b t=%0t", i, clk_en_out[i], e, $time);
                end
            end
            n_cmp++;
            if (bus_rdata !== m_read(bus_addr)) begin
                n_bad++;
                $display("FAIL R1/R5 read @%h actual=%h expected=%h", bus_addr, bus_rdata, m_read(bus_addr));
            end
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic go_chk(string tag);
        wr(12'h138, 32'h1);
        bus_addr = 12'h13C;
        #1;
        check(bus_rdata[0] === 1'b1, tag, {31'b0, bus_rdata[0]}, 32'h1);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            bus_addr = 12'h13C;
            #1;
            if (bus_rdata[0] == 1'b0) break;
        end
        check(bus_rdata[0] === 1'b0, "R5 idle", {31'b0, bus_rdata[0]}, 32'h0);
    endtask

    task automatic count_pulses(int ch, int cycles, int exp, string tag);
        int c = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            #1;
            if (clk_en_out[ch]) c++;
        end
        check(c == exp, tag, 32'(c), 32'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        rd_chk(12'h118, 32'h8000, "R10 ch0 reset");
        rd_chk(12'h164, 32'h8000, "R10 ch3 reset");
        rd_chk(12'h13C, 32'h0, "R10 status reset");
        check(clk_en_out === 4'hF, "R10 pulses", {28'b0, clk_en_out}, 32'hF);
        // R11 first commit accepted at once (R3 status raised)
        go_chk("R11 R3 first commit");
        @(negedge clk);
        rd_chk(12'h13C, 32'h0, "R5 clear after ratio-1 switch");
        // R1 program pending values
        wr(12'h118, 32'h8002);
        wr(12'h11C, 32'h8004);
        wr(12'h160, 32'h0003);
        wr(12'h164, 32'h8007);
        rd_chk(12'h118, 32'h8002, "R1 ch0");
        rd_chk(12'h11C, 32'h8004, "R1 ch1");
        rd_chk(12'h160, 32'h0003, "R1 ch2");
        rd_chk(12'h164, 32'h8007, "R1 ch3");
        // R2 nothing changes yet
        count_pulses(0, 10, 10, "R2 ch0 still ratio 1");
        go_chk("R3 commit");
        wait_idle();
        // R9 / R8 ratios
        count_pulses(0, 120, 40, "R9 ch0 ratio 3");
        count_pulses(1, 120, 24, "R9 ch1 ratio 5");
        count_pulses(3, 120, 15, "R9 ch3 ratio 8");
        count_pulses(2, 120, 0, "R8 ch2 disabled");
        // R6 / R7 second commit during transition
        wr(12'h118, 32'h8006);
        go_chk("R3 commit ratio 7");
        wr(12'h118, 32'h8001);
        wr(12'h138, 32'h1);
        wait_idle();
        count_pulses(0, 140, 20, "R6 R7 ch0 kept ratio 7");
        rd_chk(12'h118, 32'h8001, "R7 pending holds new write");
        go_chk("R3 commit ratio 2");
        wait_idle();
        count_pulses(0, 140, 70, "R7 ch0 ratio 2 after next commit");
        // R12 unmapped and null command
        wr(12'h120, 32'hFFFF_FFFF);
        rd_chk(12'h120, 32'h0, "R12 unmapped read");
        wr(12'h138, 32'h2);
        bus_addr = 12'h13C;
        #1;
        check(bus_rdata === 32'h0, "R12 null command", bus_rdata, 32'h0);
        rd_chk(12'h118, 32'h8001, "R12 ch0 untouched");
        // ratio 32 edge (R9)
        wr(12'h164, 32'h801F);
        go_chk("R3 commit ratio 32");
        wait_idle();
        count_pulses(3, 128, 4, "R9 ch3 ratio 32");
        // random traffic, checked every cycle by the model
        for (int k = 0; k < 3000; k++) begin
            int r;
            @(negedge clk);
            r = int'($urandom % 10);
            bus_wr = 1'b0;
            bus_addr = OFS[$urandom % 4];
            if (r < 3) begin
                bus_wr = 1'b1;
                bus_wdata = {16'b0, 1'($urandom), 10'b0, 5'($urandom)};
            end else if (r == 3) begin
                bus_wr = 1'b1; bus_addr = 12'h138; bus_wdata = 32'h1;
            end else if (r == 4) begin
                bus_addr = 12'h13C;
            end else if (r == 5) begin
                bus_addr = 12'h128;
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (5) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule